// File: doc/BRIEF.md
# Rectangular Blit Engine Sequencer

This block moves a rectangle of bytes from one area of a byte-addressed frame memory to another. For every byte it merges the source value with the current destination value through a raster operation. A host sets up the rectangle over a small 32-bit register bus: the rectangle size, one row pitch for each side, one start address for each side, a mode byte and a raster-operation byte. It then writes a start command and polls a busy flag until the transfer is done.

The engine is the only master of a single-port synchronous memory. That memory has separate read and write strobes and returns read data one cycle after the read strobe. The engine walks rows upward in address or, for overlapping copies where the destination lies above the source, downward from the last byte. When a transfer ends, the two address registers point one row step beyond the last row processed, so the next blit can continue from there. The geometry registers keep the values the host wrote.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset the busy flag is 0, both memory strobes are 0, and every register reads back as zero.
- R2: The register bus writes 32-bit words at word-aligned offsets. Each byte enable selects one byte lane. The offsets are:
  - 0x08: width in bits [10:0] and height in bits [25:16].
  - 0x0C: destination pitch in bits [11:0] and source pitch in bits [27:16].
  - 0x10: destination address.
  - 0x14: source address.
  - 0x18: mode byte in bits [7:0] and raster-operation byte in bits [23:16].
  - 0x40: command in bits [7:0].
  A read returns the register at `bus_addr` combinationally.
- R3: Writing command bit 1 (lane 0) while idle starts a blit. Bit 0 of offset 0x40 reads 1 from the cycle after the start write until the last byte has been written, then reads 0. Both strobes stay low while idle.
- R4: The raster-operation byte selects the result. 0x0D gives the source byte. 0x59 gives source XOR destination. 0x05 gives source AND destination. 0x6D gives source OR destination. 0x00, and any other code, writes the destination byte back unchanged.
- R5: Each byte takes three cycles. First the source byte is read. Then the destination byte is read, which is skipped for 0x0D. Then the result is written. The two strobes are never high together, and writes are never in consecutive cycles.
- R6: The width and height fields hold the count minus one. A forward blit processes height+1 rows of width+1 bytes. Addresses increase within a row, and each row start advances by its own pitch.
- R7: Mode bit 0 selects a backward walk. The programmed addresses then name the last byte of the rectangle, addresses decrease within a row, and each row start moves back by its pitch. Overlapping copies done this way move the data intact.
- R8: When a blit ends, each address register reads its start value plus (forward) or minus (backward) (height+1) times its pitch, modulo the address width. Every other register is unchanged.
- R9: A start command written while busy is ignored. Register writes made during a blit update the registers but do not change the blit in progress.
- R10: Mode bits [5:4] hold the pixel depth code and read back. Width is always counted in bytes, so depth does not change a transfer. Mode bits other than 0, 4 and 5 read as 0.
- R11: Register fields keep only their defined bits: width 11, height 10, each pitch 12, addresses ADDR_W. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |

## Verification
The assertions rely on two things about the environment. First, the memory returns read data exactly one cycle after a read strobe and never stalls. Second, reset is held from time zero until the first bus access. The bench keeps to both: its memory model registers read data on every strobed edge, and it drives bus writes only between falling edges once reset is released. Stimulus is kept inside the field limits and the model's 4 KiB address space, so that address wrap does not occur in the transfer vectors. Field truncation is exercised separately through register readback alone.

// File: rtl/rect_blit_engine.sv
module rect_blit_engine #(
  parameter int ADDR_W = 16,
  parameter int WID_W  = 11,
  parameter int HGT_W  = 10,
  parameter int PIT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [6:0]        bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam logic [7:0] OP_SRC = 8'h0D;
  localparam logic [7:0] OP_XOR = 8'h59;
  localparam logic [7:0] OP_AND = 8'h05;
  localparam logic [7:0] OP_OR  = 8'h6D;
  localparam logic [4:0] W_GEOM = 5'h02, W_PITCH = 5'h03, W_DADR = 5'h04,
                         W_SADR = 5'h05, W_MODE = 5'h06, W_CMD = 5'h10;

  typedef enum logic [1:0] {S_IDLE, S_RS, S_RD, S_WR} st_t;
  st_t st;

  logic [WID_W-1:0]  wid_r, wid_l, col;
  logic [HGT_W-1:0]  hgt_r, hgt_l, row;
  logic [PIT_W-1:0]  dpit_r, spit_r, dpit_l, spit_l;
  logic [ADDR_W-1:0] dadr_r, sadr_r, rsrc, rdst, src_a, dst_a, nsrc, ndst;
  logic [7:0]        rop_r, rop_l, src_q, result;
  logic [1:0]        dep_r;
  logic              back_r, back_l;
  logic [31:0]       wmerge;
  logic              busy, need_dst, row_end, last, start;
  logic              unused_bits;

  assign busy     = st != S_IDLE;
  assign need_dst = rop_l != OP_SRC;
  assign row_end  = col == wid_l;
  assign last     = row_end && row == hgt_l;
  assign start    = bus_wr && bus_addr[6:2] == W_CMD && bus_be[0] && bus_wdata[1] && !busy;

  assign src_a = back_l ? rsrc - ADDR_W'(col) : rsrc + ADDR_W'(col);
  assign dst_a = back_l ? rdst - ADDR_W'(col) : rdst + ADDR_W'(col);
  assign nsrc  = back_l ? rsrc - ADDR_W'(spit_l) : rsrc + ADDR_W'(spit_l);
  assign ndst  = back_l ? rdst - ADDR_W'(dpit_l) : rdst + ADDR_W'(dpit_l);

  assign mem_rd    = (st == S_RS) || (st == S_RD && need_dst);
  assign mem_wr    = st == S_WR;
  assign mem_addr  = (st == S_RS) ? src_a : dst_a;
  assign mem_wdata = result;

  always_comb begin
    case (rop_l)
      OP_SRC:  result = src_q;
      OP_XOR:  result = src_q ^ mem_rdata;
      OP_AND:  result = src_q & mem_rdata;
      OP_OR:   result = src_q | mem_rdata;
      default: result = mem_rdata;
    endcase
  end

  always_comb begin
    case (bus_addr[6:2])
      W_GEOM:  bus_rdata = {{(16-HGT_W){1'b0}}, hgt_r, {(16-WID_W){1'b0}}, wid_r};
      W_PITCH: bus_rdata = {{(16-PIT_W){1'b0}}, spit_r, {(16-PIT_W){1'b0}}, dpit_r};
      W_DADR:  bus_rdata = 32'(dadr_r);
      W_SADR:  bus_rdata = 32'(sadr_r);
      W_MODE:  bus_rdata = {8'h00, rop_r, 8'h00, 2'b00, dep_r, 3'b000, back_r};
      W_CMD:   bus_rdata = {31'b0, busy};
      default: bus_rdata = 32'b0;
    endcase
  end

  always_comb
    for (int i = 0; i < 4; i++)
      wmerge[8*i +: 8] = bus_be[i] ? bus_wdata[8*i +: 8] : bus_rdata[8*i +: 8];

  assign unused_bits = ^{wmerge, bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wid_r <= '0; hgt_r <= '0; dpit_r <= '0; spit_r <= '0;
      dadr_r <= '0; sadr_r <= '0; rop_r <= '0; dep_r <= '0; back_r <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr[6:2])
          W_GEOM:  begin wid_r <= wmerge[WID_W-1:0]; hgt_r <= wmerge[16 +: HGT_W]; end
          W_PITCH: begin dpit_r <= wmerge[PIT_W-1:0]; spit_r <= wmerge[16 +: PIT_W]; end
          W_DADR:  dadr_r <= wmerge[ADDR_W-1:0];
          W_SADR:  sadr_r <= wmerge[ADDR_W-1:0];
          W_MODE:  begin back_r <= wmerge[0]; dep_r <= wmerge[5:4]; rop_r <= wmerge[23:16]; end
          default: ;
        endcase
      end
      if (st == S_WR && last) begin
        sadr_r <= nsrc;
        dadr_r <= ndst;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wid_l <= '0; hgt_l <= '0; dpit_l <= '0; spit_l <= '0;
      rop_l <= '0; back_l <= 1'b0; col <= '0; row <= '0;
      rsrc <= '0; rdst <= '0; src_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          wid_l <= wid_r; hgt_l <= hgt_r; dpit_l <= dpit_r; spit_l <= spit_r;
          rop_l <= rop_r; back_l <= back_r; rsrc <= sadr_r; rdst <= dadr_r;
          col <= '0; row <= '0;
          st <= S_RS;
        end
        S_RS: st <= S_RD;
        S_RD: begin
          src_q <= mem_rdata;
          st <= S_WR;
        end
        S_WR: begin
          if (row_end) begin
            col  <= '0;
            row  <= row + 1'b1;
            rsrc <= nsrc;
            rdst <= ndst;
          end else begin
            col <= col + 1'b1;
          end
          st <= last ? S_IDLE : S_RS;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd && !mem_wr);
  assert_counter_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> col <= wid_l && row <= hgt_l);
  assert_blit_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(st == S_WR && last)) |=> busy && $stable(rop_l) && $stable(wid_l) && $stable(back_l));
  assert_end_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && last) |=> !busy);
endmodule

// File: tb/rect_blit_engine_bench.sv
module rect_blit_engine_bench;
  localparam int AW = 12;
  localparam int MSZ = 1 << AW;

  typedef struct packed {
    logic [7:0]  rop;
    logic [7:0]  mode;
    logic [10:0] w;
    logic [9:0]  h;
    logic [11:0] sp;
    logic [11:0] dp;
    logic [11:0] sa;
    logic [11:0] da;
    logic [3:0]  req;
  } vec_t;

  // R4 ROP codes, R6 forward walk, R7 backward overlap, R10 depth ignored
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h0D, 8'h00, 11'd15, 10'd3, 12'd64,  12'd64,  12'h100, 12'h400, 4'd6},
    '{8'h59, 8'h00, 11'd7,  10'd4, 12'd32,  12'd48,  12'h200, 12'h600, 4'd4},
    '{8'h05, 8'h00, 11'd9,  10'd2, 12'd20,  12'd100, 12'h300, 12'h700, 4'd4},
    '{8'h6D, 8'h20, 11'd5,  10'd5, 12'd16,  12'd16,  12'h380, 12'h800, 4'd10},
    '{8'h00, 8'h00, 11'd10, 10'd2, 12'd40,  12'd40,  12'h900, 12'hA00, 4'd4},
    '{8'h0D, 8'h00, 11'd31, 10'd3, 12'd64,  12'd64,  12'hB10, 12'hB00, 4'd6},
    '{8'h0D, 8'h01, 11'd23, 10'd3, 12'd64,  12'd64,  12'hCD7, 12'hCDF, 4'd7},
    '{8'h59, 8'h01, 11'd6,  10'd2, 12'd30,  12'd50,  12'hE50, 12'hF70, 4'd7},
    '{8'h0D, 8'h30, 11'd0,  10'd0, 12'd9,   12'd9,   12'h050, 12'h060, 4'd6},
    '{8'h33, 8'h00, 11'd3,  10'd1, 12'd8,   12'd8,   12'h0A0, 12'h0C0, 4'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] fmem [MSZ];
  logic [7:0] rmem [MSZ];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rect_blit_engine #(.ADDR_W(AW)) u_rect_blit_engine (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_be, .bus_wdata, .bus_rdata,
    .mem_rd, .mem_wr, .mem_addr, .mem_wdata, .mem_rdata);

  always @(posedge clk) begin
    if (mem_wr) fmem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= fmem[mem_addr];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic prog(input vec_t v);
    wr(7'h08, {6'b0, v.h, 5'b0, v.w}, 4'hF);
    wr(7'h0C, {4'b0, v.sp, 4'b0, v.dp}, 4'hF);
    wr(7'h10, 32'(v.da), 4'hF);
    wr(7'h14, 32'(v.sa), 4'hF);
    wr(7'h18, {8'h00, v.rop, 8'h00, v.mode}, 4'hF);
  endtask

  task automatic model(input vec_t v);
    for (int r = 0; r <= int'(v.h); r++)
      for (int c = 0; c <= int'(v.w); c++) begin
        logic [11:0] s, d;
        logic [7:0] x, y;
        s = v.mode[0] ? 12'(v.sa - r*v.sp - c) : 12'(v.sa + r*v.sp + c);
        d = v.mode[0] ? 12'(v.da - r*v.dp - c) : 12'(v.da + r*v.dp + c);
        x = rmem[s]; y = rmem[d];
        case (v.rop)
          8'h0D: rmem[d] = x;
          8'h59: rmem[d] = x ^ y;
          8'h05: rmem[d] = x & y;
          8'h6D: rmem[d] = x | y;
          default: rmem[d] = y;
        endcase
      end
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int n = 0; n < 20000; n++) begin
      rd(7'h40, d);
      if (d[0] == 1'b0) break;
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < MSZ; i++)
      if (fmem[i] !== rmem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s memory mismatches=%0d at %h actual=%h expected=%h",
               req, bad, first, fmem[first], rmem[first]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    vec_t v;
    for (int i = 0; i < MSZ; i++) begin
      fmem[i] = 8'((i * 37) ^ (i >> 4) ^ 8'h5A);
      rmem[i] = fmem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mem_rd", 32'(mem_rd), 0);
    chk("R1", "mem_wr", 32'(mem_wr), 0);
    rst_n = 1'b1;
    rd(7'h08, d); chk("R1", "geom", d, 0);
    rd(7'h14, d); chk("R1", "src addr", d, 0);
    rd(7'h18, d); chk("R1", "mode", d, 0);
    rd(7'h40, d); chk("R1", "busy", d, 0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      logic [11:0] es, ed;
      v = VECS[k];
      tag = $sformatf("R%0d v%0d", v.req, k);
      prog(v);
      model(v);
      wr(7'h40, 32'h2, 4'h1);
      rd(7'h40, d); chk("R3", "busy after start", d, 1);
      wait_idle();
      cmp_mem(tag);
      es = v.mode[0] ? 12'(v.sa - (v.h + 1) * v.sp) : 12'(v.sa + (v.h + 1) * v.sp);
      ed = v.mode[0] ? 12'(v.da - (v.h + 1) * v.dp) : 12'(v.da + (v.h + 1) * v.dp);
      rd(7'h14, d); chk("R8", "src addr end", d, 32'(es));
      rd(7'h10, d); chk("R8", "dst addr end", d, 32'(ed));
      rd(7'h08, d); chk("R8", "geom kept", d, {6'b0, v.h, 5'b0, v.w});
      rd(7'h0C, d); chk("R8", "pitch kept", d, {4'b0, v.sp, 4'b0, v.dp});
      rd(7'h18, d); chk("R10", "mode kept", d, {8'h00, v.rop, 8'h00, v.mode & 8'h31});
    end

    // R9 writes and a second start during a blit
    v = '{8'h0D, 8'h00, 11'd15, 10'd5, 12'd32, 12'd32, 12'h500, 12'h5C0, 4'd9};
    prog(v);
    model(v);
    wr(7'h40, 32'h2, 4'h1);
    wr(7'h18, 32'h0059_0001, 4'hF);
    wr(7'h08, 32'h0000_0002, 4'hF);
    wr(7'h40, 32'h2, 4'h1);
    rd(7'h40, d); chk("R9", "still busy", d, 1);
    wait_idle();
    cmp_mem("R9");
    repeat (4) @(negedge clk);
    rd(7'h40, d); chk("R9", "second start ignored", d, 0);
    chk("R9", "no strobes after", 32'({mem_rd, mem_wr}), 0);
    rd(7'h08, d); chk("R9", "width reg updated", d, 32'h2);
    rd(7'h18, d); chk("R9", "rop reg updated", d, 32'h0059_0001);
    rd(7'h14, d); chk("R8", "src end after R9 run", d, 32'(12'h500 + 6 * 32));

    // R11 field truncation, R2 byte lanes
    wr(7'h08, 32'hFFFF_FFFF, 4'hF); rd(7'h08, d); chk("R11", "geom trunc", d, 32'h03FF_07FF);
    wr(7'h0C, 32'hFFFF_FFFF, 4'hF); rd(7'h0C, d); chk("R11", "pitch trunc", d, 32'h0FFF_0FFF);
    wr(7'h10, 32'hFFFF_FFFF, 4'hF); rd(7'h10, d); chk("R11", "addr trunc", d, 32'h0000_0FFF);
    wr(7'h18, 32'hFFFF_FFFF, 4'hF); rd(7'h18, d); chk("R10", "mode bits", d, 32'h00FF_0031);
    wr(7'h18, 32'h00AB_0000, 4'b0100); rd(7'h18, d); chk("R2", "rop lane only", d, 32'h00AB_0031);
    wr(7'h08, 32'h0000_0123, 4'b0011); rd(7'h08, d); chk("R2", "width lanes", d, 32'h03FF_0123);
    wr(7'h40, 32'h0000_0001, 4'h1); rd(7'h40, d); chk("R3", "bit0 alone no start", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule